// File: doc/BRIEF.md
# Edge-List Digital Pulse Sequencer

This block drives a bank of digital output lines from a timed list held in local memory. The list gives a starting level for every line and a set of change events. Each event carries an absolute time in timebase ticks and the full output word that takes effect from that time on. Storage therefore grows with the number of output changes and not with the length of the sequence. Once a run starts, the host transfers nothing.

The host fills the event memory, the starting word and the event count through one write port while the sequencer is idle. A start pulse loads the starting word onto the outputs and clears the timebase. The engine then walks the events in order, applying each one when the tick count equals its stored time. With the default of five 125 MHz clocks per tick, the timing step is 40 ns. The next event is always fetched ahead of time, so events on consecutive ticks are both honoured. After the last event the outputs keep their final word and a completion flag rises. Host writes attempted during a run are refused and reported.

Top module: `edge_seq`

## Requirements
- R1: After reset, `ttl_out` is all zero and `busy`, `done` and `wr_err` are 0.
- R2: A `start` pulse while idle makes `busy` 1 and `done` 0 at the next clock edge, called the start edge, and `ttl_out` shows the stored starting word from that edge on.
- R3: An event with time T sets `ttl_out` to its output word at the clock edge T*TICK_DIV+1 after the start edge. Events are applied in address order starting from address 0, and times must strictly increase.
- R4: Events whose times differ by one tick are both applied, TICK_DIV clock edges apart, with no event skipped.
- R5: One edge after the last counted event is applied, `busy` falls and `done` rises, and `ttl_out` holds its final word while idle. With a count of zero this happens at the edge after the start edge, and the outputs keep the starting word.
- R6: A `start` pulse while `busy` is 1 has no effect on the outputs or on the run timing.
- R7: A write while `busy` is 1, or in the same cycle as a `start` pulse, is discarded. `wr_err` is then 1 for exactly the one cycle after that write, and it is 0 at all other times.
- R8: A count value written above DEPTH is stored as DEPTH.
- R9: `wr_sel` encoding: 0 writes event `wr_addr` with time `wr_time` and word `wr_data`; 1 writes the starting word from `wr_data`; 2 writes the event count from `wr_data`; 3 changes nothing and raises no error.
- R10: `done` stays 1 until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target (see R9) |
| wr_addr | input | ADDR_W | Event address |
| wr_time | input | TIME_W | Event time in ticks |
| wr_data | input | CHAN_W | Output word, starting word or count |
| start | input | 1 | Start pulse |
| ttl_out | output | CHAN_W | Output lines |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| wr_err | output | 1 | Write refused (one-cycle pulse) |

## Verification
The hardest situations to reach are the collisions at the run boundaries. One is a write issued in the very cycle of an accepted start. Another is a start or a write arriving in the middle of a run. A third is a run in which every event falls on consecutive ticks up to a count that saturated at DEPTH. The bench drives these from inside its per-cycle sampling loop at chosen cycle offsets. It compares every output cycle against a timeline computed from the event list. It then repeats an earlier run to show that refused writes left the memory unchanged.

// File: rtl/edge_seq_pkg.sv
package edge_seq_pkg;
    typedef enum logic [1:0] {
        SEL_EVENT = 2'd0,
        SEL_START = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_NONE  = 2'd3
    } wsel_e;
endpackage

// File: rtl/edge_seq_store.sv
module edge_seq_store #(
    parameter int CHAN_W = 32,
    parameter int TIME_W = 32,
    parameter int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [TIME_W-1:0] wr_time_i,
    input  logic [CHAN_W-1:0] wr_data_i,
    input  logic              lock_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [TIME_W-1:0] rd_time_o,
    output logic [CHAN_W-1:0] rd_outs_o,
    output logic [CHAN_W-1:0] init_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              wr_err_o
);
    import edge_seq_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CHAN_W-1:0] init;
        logic              err;
        logic [TIME_W-1:0] rd_time;
        logic [CHAN_W-1:0] rd_outs;
    } store_t;

    logic [TIME_W-1:0] mem_time [DEPTH];
    logic [CHAN_W-1:0] mem_outs [DEPTH];
    store_t st_d, st_q;
    logic   wr_ok;

    always_comb begin
        wr_ok      = wr_en_i && !lock_i;
        st_d       = st_q;
        st_d.err   = wr_en_i && lock_i;
        st_d.rd_time = mem_time[rd_addr_i];
        st_d.rd_outs = mem_outs[rd_addr_i];
        if (wr_ok && wr_sel_i == SEL_START) begin
            st_d.init = wr_data_i;
        end
        if (wr_ok && wr_sel_i == SEL_COUNT) begin
            if (wr_data_i > CHAN_W'(DEPTH)) begin
                st_d.count = CNT_W'(DEPTH);
            end else begin
                st_d.count = wr_data_i[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && wr_sel_i == SEL_EVENT) begin
            mem_time[wr_addr_i] <= wr_time_i;
            mem_outs[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_time_o = st_q.rd_time;
    assign rd_outs_o = st_q.rd_outs;
    assign init_o    = st_q.init;
    assign count_o   = st_q.count;
    assign wr_err_o  = st_q.err;

    AST_ERR_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && lock_i) |=> wr_err_o); // R7
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && lock_i) |=> !wr_err_o); // R7
    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH)); // R8
    AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> ($stable(init_o) && $stable(count_o))); // R7
endmodule

// File: rtl/edge_seq_engine.sv
module edge_seq_engine #(
    parameter int CHAN_W   = 32,
    parameter int TIME_W   = 32,
    parameter int DEPTH    = 16,
    parameter int TICK_DIV = 5,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int DIV_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CHAN_W-1:0] init_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [TIME_W-1:0] ev_time_i,
    input  logic [CHAN_W-1:0] ev_outs_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [CHAN_W-1:0] outs_o,
    output logic              busy_o,
    output logic              done_o
);
    typedef struct packed {
        logic              running;
        logic              fin;
        logic [CNT_W-1:0]  idx;
        logic [TIME_W-1:0] tick;
        logic [DIV_W-1:0]  div;
        logic [CHAN_W-1:0] outs;
    } eng_t;

    eng_t eng_d, eng_q;
    logic apply;

    always_comb begin
        eng_d = eng_q;
        apply = eng_q.running && (eng_q.div == '0) && (eng_q.idx < count_i)
                && (ev_time_i == eng_q.tick);
        if (!eng_q.running) begin
            if (start_i) begin
                eng_d.running = 1'b1;
                eng_d.fin     = 1'b0;
                eng_d.idx     = '0;
                eng_d.tick    = '0;
                eng_d.div     = '0;
                eng_d.outs    = init_i;
            end
        end else if (eng_q.idx == count_i) begin
            eng_d.running = 1'b0;
            eng_d.fin     = 1'b1;
        end else begin
            if (eng_q.div == DIV_W'(TICK_DIV - 1)) begin
                eng_d.div  = '0;
                eng_d.tick = eng_q.tick + 1'b1;
            end else begin
                eng_d.div = eng_q.div + 1'b1;
            end
            if (apply) begin
                eng_d.outs = ev_outs_i;
                eng_d.idx  = eng_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign rd_addr_o = eng_d.idx[ADDR_W-1:0];
    assign outs_o    = eng_q.outs;
    assign busy_o    = eng_q.running;
    assign done_o    = eng_q.fin;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o && outs_o == $past(init_i))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(outs_o)); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (eng_q.idx <= count_i)); // R5
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && eng_q.idx != count_i && eng_q.div == DIV_W'(TICK_DIV - 1))
        |=> (eng_q.tick == $past(eng_q.tick) + 1'b1)); // R3
endmodule

// File: rtl/edge_seq.sv
module edge_seq #(
    parameter int CHAN_W   = 32,
    parameter int TIME_W   = 32,
    parameter int DEPTH    = 16,
    parameter int TICK_DIV = 5,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TIME_W-1:0] wr_time,
    input  logic [CHAN_W-1:0] wr_data,
    input  logic              start,
    output logic [CHAN_W-1:0] ttl_out,
    output logic              busy,
    output logic              done,
    output logic              wr_err
);
    logic [ADDR_W-1:0] rd_addr;
    logic [TIME_W-1:0] ev_time;
    logic [CHAN_W-1:0] ev_outs;
    logic [CHAN_W-1:0] init_word;
    logic [CNT_W-1:0]  ev_count;
    logic              lock;

    assign lock = busy || start;

    edge_seq_store #(
        .CHAN_W(CHAN_W), .TIME_W(TIME_W), .DEPTH(DEPTH)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_addr_i(wr_addr),
        .wr_time_i(wr_time), .wr_data_i(wr_data), .lock_i(lock),
        .rd_addr_i(rd_addr), .rd_time_o(ev_time), .rd_outs_o(ev_outs),
        .init_o(init_word), .count_o(ev_count), .wr_err_o(wr_err)
    );

    edge_seq_engine #(
        .CHAN_W(CHAN_W), .TIME_W(TIME_W), .DEPTH(DEPTH), .TICK_DIV(TICK_DIV)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .init_i(init_word), .count_i(ev_count),
        .ev_time_i(ev_time), .ev_outs_i(ev_outs),
        .rd_addr_o(rd_addr), .outs_o(ttl_out),
        .busy_o(busy), .done_o(done)
    );
endmodule

// File: tb/sim_edge_seq.sv
module sim_edge_seq;
    localparam int DIV = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [3:0]  wr_addr = 4'd0;
    logic [31:0] wr_time = 32'd0;
    logic [31:0] wr_data = 32'd0;
    logic        start = 1'b0;
    logic [31:0] ttl_out;
    logic        busy, done, wr_err;

    int checks = 0;
    int errors = 0;

    int          ev_t [16];
    logic [31:0] ev_o [16];
    int          ev_n;
    logic [31:0] ev_init;
    int          inj_start_c;
    int          inj_wr_c;
    bit          wr_with_start;

    always #4 clk = ~clk;

    edge_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_time(wr_time), .wr_data(wr_data),
        .start(start), .ttl_out(ttl_out), .busy(busy), .done(done),
        .wr_err(wr_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] sel, input int addr, input int t, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = 4'(addr); wr_time = 32'(t); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_list(input logic [31:0] init, input int n, input int cnt_written);
        host_wr(2'd1, 0, 0, init);
        for (int k = 0; k < n; k++) host_wr(2'd0, k, ev_t[k], ev_o[k]);
        host_wr(2'd2, 0, 0, 32'(cnt_written));
        ev_init = init;
        ev_n = n;
    endtask

    // runs one sequence and compares every cycle against the computed timeline
    task automatic run_seq(input string tag);
        int done_c;
        logic [31:0] e;
        done_c = (ev_n == 0) ? 1 : ev_t[ev_n-1] * DIV + 2;
        @(negedge clk);
        start = 1'b1;
        if (wr_with_start) begin
            wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'hFFFF_0000;
        end
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        for (int c = 0; c <= done_c + 2; c++) begin
            e = ev_init;
            for (int k = 0; k < ev_n; k++) if (c >= ev_t[k] * DIV + 1) e = ev_o[k];
            check({tag, " R3/R4 ttl_out"}, ttl_out, e);
            check({tag, " R2/R5 busy"}, {31'd0, busy}, {31'd0, c < done_c});
            check({tag, " R5/R10 done"}, {31'd0, done}, {31'd0, c >= done_c});
            if (wr_with_start && c == 0)
                check({tag, " R7 err on start-cycle write"}, {31'd0, wr_err}, 32'd1);
            else
                check({tag, " R7 wr_err"}, {31'd0, wr_err}, {31'd0, c == inj_wr_c + 1});
            start = (c == inj_start_c);
            wr_en = (c == inj_wr_c);
            if (c == inj_wr_c) begin
                wr_sel = 2'd0; wr_addr = 4'd0; wr_time = 32'd99; wr_data = 32'hDEAD_BEEF;
            end
            @(negedge clk);
        end
        start = 1'b0; wr_en = 1'b0;
        inj_start_c = -10; inj_wr_c = -10; wr_with_start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        inj_start_c = -10; inj_wr_c = -10; wr_with_start = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 ttl_out reset", ttl_out, 32'd0);
        check("R1 busy reset", {31'd0, busy}, 32'd0);
        check("R1 done reset", {31'd0, done}, 32'd0);
        check("R1 wr_err reset", {31'd0, wr_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // back-to-back ticks 1,2,3 then gaps (R3, R4, R5)
        ev_t[0] = 1; ev_t[1] = 2; ev_t[2] = 3; ev_t[3] = 7; ev_t[4] = 8; ev_t[5] = 20;
        for (int k = 0; k < 6; k++) ev_o[k] = (32'(k + 1) * 32'h1111_1111) ^ 32'h8000_0001;
        load_list(32'h0000_00FF, 6, 6);
        run_seq("listA");

        // start and write during run are ignored/refused (R6, R7)
        inj_start_c = 10; inj_wr_c = 12;
        run_seq("listA inject R6");
        run_seq("listA rerun R7");

        // event at time zero
        ev_t[0] = 0; ev_o[0] = 32'h5A5A_0F0F;
        load_list(32'h1234_5678, 1, 1);
        run_seq("time0 R3");

        // count zero keeps starting word (R5)
        load_list(32'hC0DE_0001, 0, 0);
        run_seq("count0 R5");

        // selector 3 changes nothing (R9)
        host_wr(2'd3, 0, 0, 32'h7777_7777);
        check("R9 sel3 no error", {31'd0, wr_err}, 32'd0);
        run_seq("sel3 R9");

        // write in start cycle refused (R7)
        wr_with_start = 1'b1;
        run_seq("startwrite R7");

        // saturating count, all events on consecutive ticks (R8, R4)
        for (int k = 0; k < 16; k++) begin
            ev_t[k] = k + 1;
            ev_o[k] = 32'h0001_0000 << k | 32'(k);
        end
        load_list(32'hAAAA_5555, 16, 40);
        run_seq("sat R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule